// File: doc/BRIEF.md
# APB GPIO Port with Per-Pin Auxiliary Control

This block is an APB slave that owns one general-purpose I/O port of up to 32 pins. Software writes an output-data register and a direction register. A third register picks the owner of each pin. When a pin's owner bit is clear, the registers drive that pin. When it is set, an auxiliary hardware source supplies both the pin's output value and its output enable. The block drives the pad data and output-enable lines. It samples the pad inputs through a two-stage synchronizer.

A read-only port view returns one value per pin. A pin that is currently driven shows its driven value. Any other pin shows its synchronized pad input. Two read-only identification words give the block's type and version. The bus never stalls and never reports an error.

Top module: `apb_gpio_port`

## Requirements
- R1: After reset, the output-data register holds the parameter DATA_RST, the direction and owner registers hold 0, `gpio_dout_o` equals DATA_RST and `gpio_oe_o` is 0.
- R2: A write to offset 0x00 loads the output-data register at the access-phase clock edge. Every pin whose owner bit is 0 then drives that register bit on `gpio_dout_o`.
- R3: A write to offset 0x04 loads the direction register. Every pin whose owner bit is 0 has `gpio_oe_o` equal to its direction bit, where 1 = output and 0 = input.
- R4: A write to offset 0x08 loads the owner register. Every pin whose owner bit is 1 takes `gpio_dout_o` from `aux_dout_i` and `gpio_oe_o` from `aux_oe_i`, with no added clock delay.
- R5: A read of offset 0x50 returns, per bit, `gpio_dout_o` if `gpio_oe_o` is 1 for that pin, and otherwise the synchronized `ext_i` bit.
- R6: `ext_i` passes through two flip-flops. A change is not visible at offset 0x50 after one rising edge, and it is visible after two.
- R7: Offset 0x6C reads the parameter VERSION_ID and offset 0x74 reads the parameter TYPE_ID.
- R8: Writes to offsets 0x50, 0x6C, 0x74 or any unmapped address change no register. Reads of unmapped addresses return 0.
- R9: `pready_o` is always 1 and `pslverr_o` is always 0. A write takes effect only when `psel_i`, `penable_i` and `pwrite_i` are all high, so a setup phase on its own changes nothing.
- R10: Offsets 0x00, 0x04 and 0x08 read back the contents of the output-data, direction and owner registers. Bits above WIDTH read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data, 0 when no read is selected |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Always 0 |
| ext_i | input | WIDTH | Pad input values (asynchronous) |
| aux_dout_i | input | WIDTH | Auxiliary output data for hardware-owned pins |
| aux_oe_i | input | WIDTH | Auxiliary output enable for hardware-owned pins |
| gpio_dout_o | output | WIDTH | Pad output data |
| gpio_oe_o | output | WIDTH | Pad output enable (1 = drive) |

## Verification
The assertions assume that the bus obeys APB phasing: the address and write data stay steady through the access phase, and a write enable is never raised without a select. The bench's bus tasks always issue a full setup phase and then one access phase, changing the address and data only on falling clock edges. The auxiliary and pad inputs are also changed only on falling edges. This keeps the latency check valid, since that check counts rising edges from a known input change. Registers are read only after the synchronizer has had at least two edges to settle, except in the single test that measures that latency on purpose.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_DATA = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MODE = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_EXT  = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_VER  = 8'h6C;
  localparam logic [ADDR_W-1:0] OFF_TYPE = 8'h74;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_MODE, SEL_EXT, SEL_VER, SEL_TYPE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_DATA: decode = SEL_DATA;
      OFF_DIR:  decode = SEL_DIR;
      OFF_MODE: decode = SEL_MODE;
      OFF_EXT:  decode = SEL_EXT;
      OFF_VER:  decode = SEL_VER;
      OFF_TYPE: decode = SEL_TYPE;
      default:  decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;
  logic [1:0]       age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // age counter lets the latency check start only after two edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  p_sync_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] sw_d_i,
  input  logic [WIDTH-1:0] sw_oe_i,
  input  logic [WIDTH-1:0] aux_d_i,
  input  logic [WIDTH-1:0] aux_oe_i,
  input  logic [WIDTH-1:0] ext_sync_i,
  output logic [WIDTH-1:0] pad_d_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] rd_val_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_d_o[i]  = mode_i[i] ? aux_d_i[i]  : sw_d_i[i];
    assign pad_oe_o[i] = mode_i[i] ? aux_oe_i[i] : sw_oe_i[i];
    assign rd_val_o[i] = pad_oe_o[i] ? pad_d_o[i] : ext_sync_i[i];

    // hardware-owned pin must not move while its auxiliary source is steady
    p_hw_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[i] && $past(mode_i[i]) && $stable(aux_d_i[i]) && $stable(aux_oe_i[i]))
        |-> ($stable(pad_d_o[i]) && $stable(pad_oe_o[i])));
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int               WIDTH      = 32,
  parameter logic [WIDTH-1:0] DATA_RST   = '0,
  parameter logic [BUS_W-1:0] VERSION_ID = 32'h0001_0200,
  parameter logic [BUS_W-1:0] TYPE_ID    = 32'h4750_4F31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  port_val_i,
  output logic [BUS_W-1:0]  prdata_o,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  mode_o
);
  logic [WIDTH-1:0] data_q, dir_q, mode_q;
  logic [BUS_W-1:0] rd_mux;
  logic             wr_en, rd_en;
  reg_sel_e         sel;

  assign sel   = decode(paddr_i);
  assign wr_en = psel_i & penable_i & pwrite_i;
  assign rd_en = psel_i & ~pwrite_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= DATA_RST;
      dir_q  <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA: data_q <= wdata_i;
        SEL_DIR:  dir_q  <= wdata_i;
        SEL_MODE: mode_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DATA: rd_mux[WIDTH-1:0] = data_q;
      SEL_DIR:  rd_mux[WIDTH-1:0] = dir_q;
      SEL_MODE: rd_mux[WIDTH-1:0] = mode_q;
      SEL_EXT:  rd_mux[WIDTH-1:0] = port_val_i;
      SEL_VER:  rd_mux = VERSION_ID;
      SEL_TYPE: rd_mux = TYPE_ID;
      default:  ;
    endcase
    prdata_o = rd_en ? rd_mux : '0;
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign mode_o = mode_q;

  p_data_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && paddr_i == OFF_DATA) |=> (data_o == $past(wdata_i)));

  p_dir_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && paddr_i == OFF_DIR) |=> (dir_o == $past(wdata_i)));

  p_ro_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && paddr_i != OFF_DATA && paddr_i != OFF_DIR && paddr_i != OFF_MODE)
      |=> ($stable(data_o) && $stable(dir_o) && $stable(mode_o)));

  p_setup_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!penable_i) |=> ($stable(data_o) && $stable(dir_o) && $stable(mode_o)));

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && sel == SEL_NONE) |-> (prdata_o == '0));
endmodule

// File: rtl/apb_gpio_port.sv
module apb_gpio_port
  import gpio_pkg::*;
#(
  parameter int               WIDTH      = 32,
  parameter logic [WIDTH-1:0] DATA_RST   = '0,
  parameter logic [BUS_W-1:0] VERSION_ID = 32'h0001_0200,
  parameter logic [BUS_W-1:0] TYPE_ID    = 32'h4750_4F31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [BUS_W-1:0]  pwdata_i,
  output logic [BUS_W-1:0]  prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [WIDTH-1:0]  ext_i,
  input  logic [WIDTH-1:0]  aux_dout_i,
  input  logic [WIDTH-1:0]  aux_oe_i,
  output logic [WIDTH-1:0]  gpio_dout_o,
  output logic [WIDTH-1:0]  gpio_oe_o
);
  logic [WIDTH-1:0] data_w, dir_w, mode_w, ext_sync_w, port_val_w;

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_i),
    .sync_o  (ext_sync_w)
  );

  gpio_regs #(
    .WIDTH      (WIDTH),
    .DATA_RST   (DATA_RST),
    .VERSION_ID (VERSION_ID),
    .TYPE_ID    (TYPE_ID)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .psel_i     (psel_i),
    .penable_i  (penable_i),
    .pwrite_i   (pwrite_i),
    .paddr_i    (paddr_i),
    .wdata_i    (pwdata_i[WIDTH-1:0]),
    .port_val_i (port_val_w),
    .prdata_o   (prdata_o),
    .data_o     (data_w),
    .dir_o      (dir_w),
    .mode_o     (mode_w)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_w),
    .sw_d_i     (data_w),
    .sw_oe_i    (dir_w),
    .aux_d_i    (aux_dout_i),
    .aux_oe_i   (aux_oe_i),
    .ext_sync_i (ext_sync_w),
    .pad_d_o    (gpio_dout_o),
    .pad_oe_o   (gpio_oe_o),
    .rd_val_o   (port_val_w)
  );

  p_sw_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == '0 && $past(mode_w) == '0) |-> (gpio_oe_o == dir_w));
endmodule

// File: tb/apb_gpio_port_bench.sv
`timescale 1ns/1ps
module apb_gpio_port_bench;
  localparam int          W    = 4;
  localparam logic [3:0]  DRST = 4'hA;
  localparam logic [31:0] VER  = 32'h0001_0200;
  localparam logic [31:0] TYP  = 32'h4750_4F31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [W-1:0] ext = '0, aux_d = '0, aux_oe = '0;
  logic [W-1:0] dout, oe;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  apb_gpio_port #(.WIDTH(W), .DATA_RST(DRST), .VERSION_ID(VER), .TYPE_ID(TYP)) u_apb_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready),
    .pslverr_o(pslverr), .ext_i(ext), .aux_dout_i(aux_d), .aux_oe_i(aux_oe),
    .gpio_dout_o(dout), .gpio_oe_o(oe));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dout", {28'd0, dout}, {28'd0, DRST});
    chk("R1 oe", {28'd0, oe}, 32'd0);
    apb_rd(8'h00, rd); chk("R1 data reg", rd, {28'd0, DRST});
    apb_rd(8'h04, rd); chk("R1 dir reg", rd, 32'd0);
    apb_rd(8'h08, rd); chk("R1 mode reg", rd, 32'd0);
    // R9 handshake outputs
    chk("R9 pready", {31'd0, pready}, 32'd1);
    chk("R9 pslverr", {31'd0, pslverr}, 32'd0);
    // R7 identification
    apb_rd(8'h6C, rd); chk("R7 version", rd, VER);
    apb_rd(8'h74, rd); chk("R7 type", rd, TYP);

    // R2 R3 R4 R5 R10: sweep every direction/owner pair
    for (int dv = 0; dv < 16; dv++) begin
      for (int mv = 0; mv < 16; mv++) begin
        logic [3:0] dv4, mv4, dd, ad, ao, ex, exp_oe, exp_d, exp_p;
        dv4 = 4'(dv); mv4 = 4'(mv);
        dd = 4'(dv * 3 + mv * 7 + 1);
        ad = 4'(dv ^ (mv * 5));
        ao = 4'(dv + mv * 11);
        ex = 4'(dv * 13 + mv);
        apb_wr(8'h00, {28'hFFFFFFF, dd});
        apb_wr(8'h04, {28'd0, dv4});
        apb_wr(8'h08, {28'd0, mv4});
        @(negedge clk); aux_d = ad; aux_oe = ao; ext = ex;
        repeat (3) @(negedge clk);
        exp_oe = (mv4 & ao) | (~mv4 & dv4);
        exp_d  = (mv4 & ad) | (~mv4 & dd);
        exp_p  = (exp_oe & exp_d) | (~exp_oe & ex);
        chk("R2/R4 dout", {28'd0, dout}, {28'd0, exp_d});
        chk("R3/R4 oe", {28'd0, oe}, {28'd0, exp_oe});
        apb_rd(8'h50, rd); chk("R5 port read", rd, {28'd0, exp_p});
        if (dv == mv) begin
          apb_rd(8'h00, rd); chk("R10 data readback", rd, {28'd0, dd});
          apb_rd(8'h04, rd); chk("R10 dir readback", rd, {28'd0, dv4});
          apb_rd(8'h08, rd); chk("R10 mode readback", rd, {28'd0, mv4});
        end
      end
    end

    // known state for the remaining tests: all software, all input
    apb_wr(8'h08, 32'd0);
    apb_wr(8'h04, 32'd0);
    apb_wr(8'h00, 32'h5);

    // R6 synchronizer latency
    @(negedge clk); ext = 4'h0;
    repeat (3) @(negedge clk);
    psel = 1; pwrite = 0; penable = 1; paddr = 8'h50; ext = 4'hF;
    #1 chk("R6 before edge", prdata, 32'd0);
    @(posedge clk); #1 chk("R6 after one edge", prdata, 32'd0);
    @(posedge clk); #1 chk("R6 after two edges", prdata, 32'hF);
    @(negedge clk); psel = 0; penable = 0;

    // R8 writes to read-only and unmapped offsets
    apb_wr(8'h50, 32'h3);
    apb_wr(8'h6C, 32'h3);
    apb_wr(8'h74, 32'h3);
    apb_wr(8'h0C, 32'h3);
    apb_wr(8'h01, 32'h3);
    apb_rd(8'h00, rd); chk("R8 data untouched", rd, 32'h5);
    apb_rd(8'h04, rd); chk("R8 dir untouched", rd, 32'h0);
    apb_rd(8'h08, rd); chk("R8 mode untouched", rd, 32'h0);
    apb_rd(8'h6C, rd); chk("R8 version untouched", rd, VER);
    apb_rd(8'h0C, rd); chk("R8 unmapped read", rd, 32'd0);
    apb_rd(8'h02, rd); chk("R8 unaligned read", rd, 32'd0);
    apb_rd(8'hFC, rd); chk("R8 top read", rd, 32'd0);

    // R9 setup phase alone does not write
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 8'h00; pwdata = 32'hC;
    @(negedge clk); psel = 0; pwrite = 0;
    apb_rd(8'h00, rd); chk("R9 setup-only write", rd, 32'h5);
    chk("R9 dout after setup-only", {28'd0, dout}, 32'h5);
    // R9 access phase without select
    @(negedge clk); psel = 0; pwrite = 1; penable = 1; paddr = 8'h04; pwdata = 32'hF;
    @(negedge clk); pwrite = 0; penable = 0;
    chk("R9 no select oe", {28'd0, oe}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule